// File: doc/BRIEF.md
# Extended-Range Interrupt Group Modifier Bank

This block holds one group-modifier bit per interrupt for an extended range of 64 interrupts. The bits live in two 32-bit memory-mapped words. Each modifier bit is paired with a group-status bit, which comes from elsewhere, to produce a 2-bit group classification for every interrupt. That classification drives the rest of the interrupt logic. It tells apart secure group 0, secure group 1 and non-secure group 1.

Software reaches the words over a plain register bus with these signals:
- address, write data, write enable and read enable;
- a flag that marks the access as secure;
- combinational read data.

Three control inputs shape both access and classification. A security-disable control decides whether non-secure accesses are honoured. An affinity-routing enable turns the whole modifier function on or off. An implemented-interrupt mask marks which interrupt slots really exist.

The bits have no meaningful reset value. The design clears them so that simulation is deterministic, but software is expected to program every implemented bit before it relies on it.

Top module: `egrp_bank`

## Requirements
- R1: Word n, for n = 1 and n = 2, sits at byte address 0xD00 + 4*n (0xD04 and 0xD08). Bit b of word n holds the modifier for interrupt ID 1024 + 32*n + b, which is index k = (n-1)*32 + b of the status, mask and code vectors. A secure write stores the implemented bits, and a secure read returns them.
- R2: A write lands on the clock edge that samples `busWe`. `busRdata` is combinational from the stored bits while `busRe` is high, and it is zero whenever `busRe` is low.
- R3: `grpCode[2k+1:2k]` is {modifier, status}. 2'b00 means secure group 0, 2'b01 means non-secure group 1 and 2'b10 means secure group 1. The pair {1,1} is reported as 2'b01, so 2'b11 never appears.
- R4: With `secDisable` = 0, a non-secure access (`busSecure` = 0) reads as zero.
- R5: With `secDisable` = 0, a non-secure write changes nothing. With `secDisable` = 1, non-secure accesses read and write exactly like secure ones.
- R6: With `affRouteEn` = 0, reads return zero, writes are ignored, and every interrupt is classified with a modifier of zero.
- R7: Where `implMask[k]` = 0, bit k reads as zero, a write leaves the stored bit unchanged, and the code for k uses a modifier of zero.
- R8: An access to any other byte address reads zero and changes no stored bit. This includes 0xD00, 0xD0C and addresses that are not word-aligned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 12 | Byte address within the register frame |
| busWdata | input | 32 | Write data |
| busWe | input | 1 | Write enable |
| busRe | input | 1 | Read enable |
| busSecure | input | 1 | 1 = secure access |
| secDisable | input | 1 | 1 = security disabled, non-secure accesses honoured |
| affRouteEn | input | 1 | Affinity routing enable for the modifier function |
| grpStatus | input | 64 | Per-interrupt group-status bits |
| implMask | input | 64 | Per-interrupt implemented flags |
| busRdata | output | 32 | Read data |
| grpCode | output | 128 | Per-interrupt 2-bit group code |

## Verification
The bench sweeps every combination of security disable and access security. It shows that a design which ignored the security state would leak stored bits to non-secure reads, or let them corrupt the words. It drives status and modifier patterns that contain the {1,1} pair, so the reserved code showing up on `grpCode` is caught. It writes while the implemented mask or affinity routing is off and then turns them back on. A design that cleared or overwrote masked bits, instead of leaving them alone, therefore reads back a wrong value. Every byte address around the two words is also written, to catch loose decoding that aliases the words at 0xD00, 0xD0C or misaligned addresses.

// File: rtl/egrp_pkg.sv
package egrp_pkg;

  parameter int unsigned REG_COUNT   = 2;
  parameter int unsigned REG_WIDTH   = 32;
  parameter int unsigned ADDR_WIDTH  = 12;
  parameter int unsigned FRAME_BASE  = 32'hD00;
  parameter int unsigned REG_STRIDE  = 4;
  parameter int unsigned FIRST_INDEX = 1;
  parameter int unsigned INT_COUNT   = REG_COUNT * REG_WIDTH;

  typedef enum logic [1:0] {
    GRP_SEC0 = 2'b00,
    GRP_NS1  = 2'b01,
    GRP_SEC1 = 2'b10
  } grpCode_e;

  // Strobes from control to datapath: one-hot word selects.
  typedef struct packed {
    logic [REG_COUNT-1:0] wrSel;
    logic [REG_COUNT-1:0] rdSel;
  } bankStrobe_t;

  function automatic grpCode_e classify(input logic modBit, input logic statBit);
    grpCode_e code;
    unique case ({modBit, statBit})
      2'b00:   code = GRP_SEC0;
      2'b10:   code = GRP_SEC1;
      default: code = GRP_NS1;   // 01 and reserved 11
    endcase
    return code;
  endfunction

endpackage

// File: rtl/egrp_ctrl.sv
module egrp_ctrl
  import egrp_pkg::*;
#(
  parameter int unsigned NUM_REGS = REG_COUNT,
  parameter int unsigned AW       = ADDR_WIDTH,
  parameter int unsigned BASE     = FRAME_BASE,
  parameter int unsigned STRIDE   = REG_STRIDE,
  parameter int unsigned FIRST    = FIRST_INDEX
) (
  input  logic [AW-1:0] busAddr,
  input  logic          busWe,
  input  logic          busRe,
  input  logic          busSecure,
  input  logic          secDisable,
  input  logic          affRouteEn,
  output bankStrobe_t   strobe
);

  logic                accessOk;
  logic [NUM_REGS-1:0] slotHit;

  // Access is honoured for secure masters, or for anyone when security is off,
  // and only while the modifier function is enabled.
  assign accessOk = (busSecure | secDisable) & affRouteEn;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_slot
    localparam logic [AW-1:0] SLOT_ADDR = AW'(BASE + STRIDE * (FIRST + i));
    assign slotHit[i] = (busAddr == SLOT_ADDR);
  end

  always_comb begin
    strobe       = '0;
    strobe.wrSel = slotHit & {NUM_REGS{busWe & accessOk}};
    strobe.rdSel = slotHit & {NUM_REGS{busRe & accessOk}};
  end

endmodule

// File: rtl/egrp_dp.sv
module egrp_dp
  import egrp_pkg::*;
#(
  parameter int unsigned NUM_REGS = REG_COUNT,
  parameter int unsigned W        = REG_WIDTH,
  localparam int unsigned NINT    = NUM_REGS * W
) (
  input  logic            clk,
  input  logic            rstN,
  input  bankStrobe_t     strobe,
  input  logic [W-1:0]    busWdata,
  input  logic            affRouteEn,
  input  logic [NINT-1:0] grpStatus,
  input  logic [NINT-1:0] implMask,
  output logic [W-1:0]    busRdata,
  output logic [2*NINT-1:0] grpCode
);

  logic [NINT-1:0] modBits;
  logic [NINT-1:0] effMod;

  // Storage: only implemented positions take the written value.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      modBits <= '0;
    end else begin
      for (int i = 0; i < int'(NUM_REGS); i++) begin
        if (strobe.wrSel[i]) begin
          modBits[i*W +: W] <= (busWdata & implMask[i*W +: W])
                             | (modBits[i*W +: W] & ~implMask[i*W +: W]);
        end
      end
    end
  end

  // Read path: OR of selected words, unimplemented bits forced to zero.
  always_comb begin
    busRdata = '0;
    for (int i = 0; i < int'(NUM_REGS); i++) begin
      if (strobe.rdSel[i]) begin
        busRdata = busRdata | (modBits[i*W +: W] & implMask[i*W +: W]);
      end
    end
  end

  assign effMod = modBits & implMask & {NINT{affRouteEn}};

  for (genvar k = 0; k < int'(NINT); k++) begin : g_cls
    assign grpCode[2*k +: 2] = classify(effMod[k], grpStatus[k]);
  end

endmodule

// File: rtl/egrp_bank.sv
module egrp_bank
  import egrp_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [ADDR_WIDTH-1:0]  busAddr,
  input  logic [REG_WIDTH-1:0]   busWdata,
  input  logic                   busWe,
  input  logic                   busRe,
  input  logic                   busSecure,
  input  logic                   secDisable,
  input  logic                   affRouteEn,
  input  logic [INT_COUNT-1:0]   grpStatus,
  input  logic [INT_COUNT-1:0]   implMask,
  output logic [REG_WIDTH-1:0]   busRdata,
  output logic [2*INT_COUNT-1:0] grpCode
);

  bankStrobe_t strobe;

  egrp_ctrl u_ctrl (
    .busAddr    (busAddr),
    .busWe      (busWe),
    .busRe      (busRe),
    .busSecure  (busSecure),
    .secDisable (secDisable),
    .affRouteEn (affRouteEn),
    .strobe     (strobe)
  );

  egrp_dp u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .busWdata   (busWdata),
    .affRouteEn (affRouteEn),
    .grpStatus  (grpStatus),
    .implMask   (implMask),
    .busRdata   (busRdata),
    .grpCode    (grpCode)
  );

endmodule

// File: rtl/egrp_bank_chk.sv
module egrp_bank_chk
  import egrp_pkg::*;
(
  input logic                   clk,
  input logic                   rstN,
  input logic [ADDR_WIDTH-1:0]  busAddr,
  input logic                   busWe,
  input logic                   busRe,
  input logic                   busSecure,
  input logic                   secDisable,
  input logic                   affRouteEn,
  input logic [INT_COUNT-1:0]   grpStatus,
  input logic [INT_COUNT-1:0]   implMask,
  input logic [REG_WIDTH-1:0]   busRdata,
  input logic [2*INT_COUNT-1:0] grpCode
);

  logic inStable;
  assign inStable = 1'b1;

  // R2: idle read port returns zero
  p_idle_read_zero_r2: assert property (@(posedge clk) disable iff (!rstN)
    !busRe |-> busRdata == '0);

  // R4: non-secure read with security enabled returns zero
  p_ns_read_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!secDisable && !busSecure) |-> busRdata == '0);

  // R5: non-secure write with security enabled leaves codes unchanged
  p_ns_write_ignored_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && !busSecure && !secDisable) |=>
      (grpStatus != $past(grpStatus) || implMask != $past(implMask) ||
       affRouteEn != $past(affRouteEn) || grpCode == $past(grpCode)));

  // R6: affinity routing off reads zero
  p_aff_off_read_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    !affRouteEn |-> busRdata == '0);

  // R8: word-misaligned addresses read zero
  p_misaligned_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr[1:0] != 2'b00) |-> busRdata == '0);

  for (genvar k = 0; k < int'(INT_COUNT); k++) begin : g_int
    // R3: reserved code never driven
    p_no_reserved_code_r3: assert property (@(posedge clk) disable iff (!rstN)
      inStable |-> grpCode[2*k +: 2] != 2'b11);
    // R7: unimplemented interrupt never classified with modifier set
    p_unimpl_mod_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
      !implMask[k] |-> grpCode[2*k+1] == 1'b0);
    // R6: affinity routing off never yields secure group 1
    p_aff_off_code_r6: assert property (@(posedge clk) disable iff (!rstN)
      !affRouteEn |-> grpCode[2*k +: 2] == {1'b0, grpStatus[k]});
  end

endmodule

bind egrp_bank egrp_bank_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .busAddr    (busAddr),
  .busWe      (busWe),
  .busRe      (busRe),
  .busSecure  (busSecure),
  .secDisable (secDisable),
  .affRouteEn (affRouteEn),
  .grpStatus  (grpStatus),
  .implMask   (implMask),
  .busRdata   (busRdata),
  .grpCode    (grpCode)
);

// File: tb/egrp_bank_tb.sv
module egrp_bank_tb;

  logic         clk = 1'b0;
  logic         rstN;
  logic [11:0]  busAddr;
  logic [31:0]  busWdata;
  logic         busWe, busRe, busSecure, secDisable, affRouteEn;
  logic [63:0]  grpStatus, implMask;
  logic [31:0]  busRdata;
  logic [127:0] grpCode;

  int  total = 0;
  int  bad   = 0;
  bit  done  = 1'b0;
  logic [31:0] model [2];

  always #5 clk = ~clk;

  egrp_bank u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata),
    .busWe(busWe), .busRe(busRe), .busSecure(busSecure),
    .secDisable(secDisable), .affRouteEn(affRouteEn),
    .grpStatus(grpStatus), .implMask(implMask),
    .busRdata(busRdata), .grpCode(grpCode)
  );

  function automatic int slotOf(input logic [11:0] a);
    for (int n = 1; n <= 2; n++) if (a == 12'(32'hD00 + 4 * n)) return n - 1;
    return -1;
  endfunction

  function automatic logic [127:0] expCodes();
    logic [127:0] v;
    for (int k = 0; k < 64; k++) begin
      logic m, s;
      m = model[k / 32][k % 32] & implMask[k] & affRouteEn;
      s = grpStatus[k];
      v[2*k +: 2] = (m && s) ? 2'b01 : {m, s};
    end
    return v;
  endfunction

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doWrite(input logic [11:0] a, input logic [31:0] d, input logic sec);
    int s;
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1; busSecure = sec;
    @(negedge clk);
    busWe = 1'b0;
    s = slotOf(a);
    if (s >= 0 && (sec || secDisable) && affRouteEn)
      model[s] = (d & implMask[s*32 +: 32]) | (model[s] & ~implMask[s*32 +: 32]);
  endtask

  task automatic doRead(input logic [11:0] a, input logic sec, input string tag);
    int s;
    logic [31:0] e;
    @(negedge clk);
    busAddr = a; busRe = 1'b1; busSecure = sec;
    #1;
    s = slotOf(a);
    e = '0;
    if (s >= 0 && (sec || secDisable) && affRouteEn) e = model[s] & implMask[s*32 +: 32];
    chk(tag, {96'd0, busRdata}, {96'd0, e});
    busRe = 1'b0;
  endtask

  task automatic codeCheck(input string tag);
    #1;
    chk(tag, grpCode, expCodes());
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; busAddr = '0; busWdata = '0; busWe = 0; busRe = 0;
    busSecure = 0; secDisable = 0; affRouteEn = 1; grpStatus = '0;
    implMask = '1;
    model[0] = '0; model[1] = '0;
    repeat (3) @(negedge clk);
    chk("R2 reset idle read", {96'd0, busRdata}, 128'd0);
    rstN = 1'b1;

    // Program known values before relying on any contents (R1).
    secDisable = 1'b1;
    doWrite(12'hD04, 32'hA5A5_F00F, 1'b1);
    doWrite(12'hD08, 32'h0123_ABCD, 1'b1);
    doRead(12'hD04, 1'b1, "R1 secure readback word1");
    doRead(12'hD08, 1'b1, "R1 secure readback word2");

    // R3: classification under several status patterns, including {1,1}.
    grpStatus = '0;                        codeCheck("R3 status zero");
    grpStatus = '1;                        codeCheck("R3 status ones");
    grpStatus = 64'hAAAA_5555_0F0F_F0F0;   codeCheck("R3 status mixed");
    for (int k = 0; k < 64; k += 7) begin
      grpStatus = 64'd1 << k;
      codeCheck("R3 status walking");
    end

    // R4/R5: sweep security-disable and access security.
    for (int sd = 0; sd < 2; sd++) begin
      for (int sw = 0; sw < 2; sw++) begin
        secDisable = sd[0];
        doWrite(12'hD04, 32'h1357_9BDF ^ (32'h1111_0000 * (sd * 2 + sw + 1)), sw[0]);
        doWrite(12'hD08, 32'hFEDC_0246 + 32'(sd * 977 + sw * 31), sw[0]);
        for (int sr = 0; sr < 2; sr++) begin
          doRead(12'hD04, sr[0], sd == 0 && sr == 0 ? "R4 ns read word1" : "R5 read word1");
          doRead(12'hD08, sr[0], sd == 0 && sr == 0 ? "R4 ns read word2" : "R5 read word2");
        end
        grpStatus = 64'h0F0F_3C3C_FFFF_0000 ^ {32'(sd), 32'(sw)};
        codeCheck("R5 codes after write sweep");
      end
    end

    // R2: write lands on the edge; read is combinational.
    secDisable = 1'b1;
    @(negedge clk);
    busAddr = 12'hD04; busWdata = 32'hDEAD_BEEF; busWe = 1'b1; busRe = 1'b1; busSecure = 1'b1;
    #1 chk("R2 old value before edge", {96'd0, busRdata}, {96'd0, model[0]});
    @(negedge clk);
    busWe = 1'b0;
    model[0] = 32'hDEAD_BEEF;
    #1 chk("R2 new value after edge", {96'd0, busRdata}, {96'd0, model[0]});
    busRe = 1'b0;
    #1 chk("R2 read enable low", {96'd0, busRdata}, 128'd0);

    // R6: affinity routing off.
    affRouteEn = 1'b0;
    doRead(12'hD04, 1'b1, "R6 aff off read");
    grpStatus = 64'h5555_AAAA_5555_AAAA;
    codeCheck("R6 aff off codes");
    doWrite(12'hD08, 32'h0000_0000, 1'b1);
    affRouteEn = 1'b1;
    doRead(12'hD08, 1'b1, "R6 aff off write ignored");
    codeCheck("R6 aff on codes restored");

    // R7: implemented mask.
    doWrite(12'hD04, 32'hFFFF_FFFF, 1'b1);
    doWrite(12'hD08, 32'hFFFF_FFFF, 1'b1);
    implMask = 64'hF0F0_00FF_FF00_0F0F;
    doRead(12'hD04, 1'b1, "R7 masked read word1");
    doRead(12'hD08, 1'b1, "R7 masked read word2");
    codeCheck("R7 masked codes");
    doWrite(12'hD04, 32'h0000_0000, 1'b1);
    doWrite(12'hD08, 32'h0000_0000, 1'b1);
    implMask = '1;
    doRead(12'hD04, 1'b1, "R7 unimplemented bits kept word1");
    doRead(12'hD08, 1'b1, "R7 unimplemented bits kept word2");
    codeCheck("R7 codes after unmask");

    // R8: every byte address around the words, plus far addresses.
    doWrite(12'hD04, 32'h3C3C_3C3C, 1'b1);
    doWrite(12'hD08, 32'hC3C3_C3C3, 1'b1);
    for (int a = 12'hCFC; a <= 12'hD13; a++) begin
      if (slotOf(12'(a)) < 0) begin
        doWrite(12'(a), 32'hFFFF_FFFF, 1'b1);
        doRead(12'(a), 1'b1, "R8 stray address read");
      end
    end
    doWrite(12'h000, 32'hFFFF_FFFF, 1'b1);
    doWrite(12'hFFC, 32'hFFFF_FFFF, 1'b1);
    doRead(12'hD04, 1'b1, "R8 word1 unchanged");
    doRead(12'hD08, 1'b1, "R8 word2 unchanged");
    codeCheck("R8 codes unchanged");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule